// File: doc/BRIEF.md
# Tri-Level PWM Gate Sequencer

This block sits between the level decoders of a synchronous buck power stage and its two gate drivers. It takes a PWM command that has already been decoded into one of three levels (high, mid, low), plus a skip-mode select that has also been decoded into three levels. From these it produces the enables for the high-side and low-side gates. Every hand-over between the two switches goes through a dead-time interval, and the interval ends only once the switch that is turning off reports that it is off.

A mid PWM level has two meanings, and the skip-mode select picks between them. With skip-mode high or mid, the low-side switch is held on for a fixed wait window (blanking followed by debounce). After that window it is released when the zero-current comparator fires, which gives discontinuous-mode operation. With skip-mode low, a mid PWM level turns both switches off at the next clock edge, because the controller has done its own zero-current detection.

All durations are given in nanoseconds and converted to clock cycles by rounding up, with a minimum of one cycle. With the default parameters this gives 2 cycles of dead time and a 33-cycle wait window (25 cycles of blanking and 8 of debounce). The interface is made of plain level pins only. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `tlpwm_gate_seq`

## Requirements
- R1: While rst_n is low, both gate enables are low. After reset they stay low for as long as en_i is low.
- R2: When en_i is low, both gate enables are low after the next clock edge, whatever the PWM and skip levels are.
- R3: pwm_lvl_i = 2'b10 (high) turns the low-side enable off at the edge that accepts the level. The high-side enable rises only after at least NOL_CYC cycles with both enables low, and only if ls_off_i was high in the cycle before. If the feedback is already high, it rises at the (NOL_CYC+1)-th edge.
- R4: pwm_lvl_i = 2'b00 (low) works the same way with the roles swapped. The high-side enable goes off first. The low-side enable rises only after at least NOL_CYC cycles with both low, and only if hs_off_i was high in the cycle before.
- R5: The two gate enables are never high in the same cycle.
- R6: pwm_lvl_i = 2'b01 (mid; 2'b11 is treated the same) with skip_lvl_i not 2'b00 turns the high side off and the low side on. If the low side was off, it comes on through dead time. The low side is then held on for WAIT_CYC cycles, counted from the edge that starts the wait.
- R7: Once the wait window has ended, the low-side enable stays on until zcd_i is high. It then drops at the next edge. Both enables then stay low until the decoded command changes.
- R8: zcd_i going high during the wait window does not release the low side early. The low side is released at the edge that ends the window, whether or not zcd_i is still high at that point.
- R9: skip_lvl_i = 2'b01 (mid) gives gate behaviour identical to skip_lvl_i = 2'b10 (high). The value 2'b11 is also treated as high.
- R10: pwm mid with skip_lvl_i = 2'b00 (low) drives both enables low at the next clock edge, with no dead time and no wait window.
- R11: A new command that arrives while a dead-time interval is running restarts that interval toward the new target.
- R12: While the low side is on, a change between PWM low and PWM mid (with skip not low) keeps the low-side enable continuously high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable from the supervisor; low forces both gates off |
| pwm_lvl_i | input | 2 | Decoded PWM level: 00 low, 01 mid, 10 high, 11 mid |
| skip_lvl_i | input | 2 | Decoded skip-mode level: 00 low, 01 mid, 10 high, 11 high |
| zcd_i | input | 1 | Zero-current comparator flag |
| hs_off_i | input | 1 | High-side switch confirmed off |
| ls_off_i | input | 1 | Low-side switch confirmed off |
| gate_hs_o | output | 1 | High-side gate enable |
| gate_ls_o | output | 1 | Low-side gate enable |

## Verification
Two events can land in the same cycle, and both cases are exercised. The first is the end of the wait window together with the comparator flag, which has either been high throughout the window or only pulsed early in it. The bench checks that the low side drops exactly one edge after the full window in both cases, and that it stays on after the window when the flag is low. The second is a new PWM level arriving while the dead-time counter is still running. The bench issues a high command and reverses it one edge later, then checks that the low side comes on only after a fresh full dead-time interval. Meanwhile the bound checker confirms that the high side never rose.

// File: rtl/tlpwm_pkg.sv
`timescale 1ns/1ps
package tlpwm_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_ALT  = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    CMD_HS,
    CMD_LS,
    CMD_ZCD,
    CMD_OFF
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HS_ON,
    ST_LS_ON,
    ST_NOL_WAIT,
    ST_ZCD_BLANK,
    ST_ZCD_ARMED,
    ST_BOTH_OFF
  } state_e;

  // Round a duration up to whole clock cycles, never below one.
  function automatic int unsigned ns2cyc(int unsigned dur_ns, int unsigned per_ns);
    int unsigned c;
    c = (dur_ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/tlpwm_cmd_map.sv
`timescale 1ns/1ps
module tlpwm_cmd_map
  import tlpwm_pkg::*;
(
  input  logic [1:0] pwm_lvl,
  input  logic [1:0] skip_lvl,
  output cmd_e       cmd
);

  always_comb begin
    if (pwm_lvl == LVL_HIGH)
      cmd = CMD_HS;
    else if (pwm_lvl == LVL_LOW)
      cmd = CMD_LS;
    else if (skip_lvl == LVL_LOW)
      cmd = CMD_OFF;   // controller-side zero detection: drop both at once
    else
      cmd = CMD_ZCD;   // skip mid and high share one gate behaviour
  end

endmodule

// File: rtl/tlpwm_dly_timer.sv
`timescale 1ns/1ps
module tlpwm_dly_timer #(
  parameter int unsigned TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/tlpwm_seq_fsm.sv
`timescale 1ns/1ps
module tlpwm_seq_fsm
  import tlpwm_pkg::*;
#(
  parameter int unsigned NOL_CYC  = 2,
  parameter int unsigned WAIT_CYC = 33,
  parameter int unsigned TW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  cmd_e          cmd,
  input  logic          zcd,
  input  logic          hs_off,
  input  logic          ls_off,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          gate_hs,
  output logic          gate_ls
);

  localparam logic [TW-1:0] NOL_LOAD  = TW'(NOL_CYC - 1);
  localparam logic [TW-1:0] WAIT_LOAD = TW'(WAIT_CYC - 1);

  state_e st_q, st_d;
  cmd_e   cmd_q, tgt_q, tgt_d;
  logic   seen_q;
  logic   ls_now;
  logic   fb_ok;

  assign ls_now = (st_q == ST_LS_ON) || (st_q == ST_ZCD_BLANK) || (st_q == ST_ZCD_ARMED);
  assign fb_ok  = (tgt_q == CMD_HS) ? ls_off : hs_off;

  always_comb begin
    st_d     = st_q;
    tgt_d    = tgt_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (!en) begin
      st_d = ST_IDLE;
    end else if (st_q == ST_IDLE || cmd != cmd_q) begin
      case (cmd)
        CMD_OFF: st_d = ST_BOTH_OFF;
        CMD_HS: begin
          st_d = ST_NOL_WAIT; tgt_d = CMD_HS; tmr_load = 1'b1; tmr_val = NOL_LOAD;
        end
        CMD_LS: begin
          if (ls_now) st_d = ST_LS_ON;
          else begin
            st_d = ST_NOL_WAIT; tgt_d = CMD_LS; tmr_load = 1'b1; tmr_val = NOL_LOAD;
          end
        end
        default: begin
          if (ls_now) begin
            st_d = ST_ZCD_BLANK; tmr_load = 1'b1; tmr_val = WAIT_LOAD;
          end else begin
            st_d = ST_NOL_WAIT; tgt_d = CMD_ZCD; tmr_load = 1'b1; tmr_val = NOL_LOAD;
          end
        end
      endcase
    end else begin
      case (st_q)
        ST_NOL_WAIT: begin
          if (tmr_zero && fb_ok) begin
            case (tgt_q)
              CMD_HS:  st_d = ST_HS_ON;
              CMD_LS:  st_d = ST_LS_ON;
              default: begin
                st_d = ST_ZCD_BLANK; tmr_load = 1'b1; tmr_val = WAIT_LOAD;
              end
            endcase
          end
        end
        ST_ZCD_BLANK: if (tmr_zero) st_d = (seen_q || zcd) ? ST_BOTH_OFF : ST_ZCD_ARMED;
        ST_ZCD_ARMED: if (zcd) st_d = ST_BOTH_OFF;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tgt_q   <= CMD_OFF;
      cmd_q   <= CMD_OFF;
      seen_q  <= 1'b0;
      gate_hs <= 1'b0;
      gate_ls <= 1'b0;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      cmd_q   <= cmd;
      if (tmr_load)
        seen_q <= 1'b0;
      else if (st_q == ST_ZCD_BLANK && zcd)
        seen_q <= 1'b1;
      gate_hs <= (st_d == ST_HS_ON);
      gate_ls <= (st_d == ST_LS_ON) || (st_d == ST_ZCD_BLANK) || (st_d == ST_ZCD_ARMED);
    end
  end

endmodule

// File: rtl/tlpwm_gate_seq.sv
`timescale 1ns/1ps
module tlpwm_gate_seq
  import tlpwm_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned DEAD_NS       = 20,
  parameter int unsigned BLANK_NS      = 250,
  parameter int unsigned DEBOUNCE_NS   = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [1:0] pwm_lvl_i,
  input  logic [1:0] skip_lvl_i,
  input  logic       zcd_i,
  input  logic       hs_off_i,
  input  logic       ls_off_i,
  output logic       gate_hs_o,
  output logic       gate_ls_o
);

  localparam int unsigned NOL_CYC   = ns2cyc(DEAD_NS, CLK_PERIOD_NS);
  localparam int unsigned BLANK_CYC = ns2cyc(BLANK_NS, CLK_PERIOD_NS);
  localparam int unsigned DEB_CYC   = ns2cyc(DEBOUNCE_NS, CLK_PERIOD_NS);
  localparam int unsigned WAIT_CYC  = BLANK_CYC + DEB_CYC;
  localparam int unsigned MAX_CYC   = (NOL_CYC > WAIT_CYC) ? NOL_CYC : WAIT_CYC;
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);

  cmd_e          cmd;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;

  tlpwm_cmd_map u_map (
    .pwm_lvl  (pwm_lvl_i),
    .skip_lvl (skip_lvl_i),
    .cmd      (cmd)
  );

  tlpwm_dly_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  tlpwm_seq_fsm #(.NOL_CYC(NOL_CYC), .WAIT_CYC(WAIT_CYC), .TW(TW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_i),
    .cmd      (cmd),
    .zcd      (zcd_i),
    .hs_off   (hs_off_i),
    .ls_off   (ls_off_i),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .gate_hs  (gate_hs_o),
    .gate_ls  (gate_ls_o)
  );

endmodule

// File: rtl/tlpwm_seq_chk.sv
`timescale 1ns/1ps
module tlpwm_seq_chk #(
  parameter int unsigned NOL_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic [1:0] pwm_lvl_i,
  input logic [1:0] skip_lvl_i,
  input logic       hs_off_i,
  input logic       ls_off_i,
  input logic       gate_hs_o,
  input logic       gate_ls_o
);

  // Cycles both gates have been low, saturating.
  logic [15:0] off_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      off_cnt <= 16'hFFFF;
    else if (gate_hs_o || gate_ls_o)
      off_cnt <= '0;
    else if (off_cnt != 16'hFFFF)
      off_cnt <= off_cnt + 1'b1;
  end

  p_exclusive_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs_o && gate_ls_o));

  p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!gate_hs_o && !gate_ls_o));

  p_hs_after_ls_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hs_o) |-> ($past(ls_off_i) && !$past(gate_ls_o)));

  p_ls_after_hs_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ls_o) |-> ($past(hs_off_i) && !$past(gate_hs_o)));

  p_dead_time_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hs_o) |-> (off_cnt >= 16'(NOL_CYC)));

  p_dead_time_ls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_ls_o) |-> (off_cnt >= 16'(NOL_CYC)));

  p_skip_low_mid_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pwm_lvl_i == 2'b01 && skip_lvl_i == 2'b00) |=> (!gate_hs_o && !gate_ls_o));

  p_ls_held_on_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && gate_ls_o && pwm_lvl_i == 2'b00) |=> gate_ls_o);

endmodule

bind tlpwm_gate_seq tlpwm_seq_chk #(.NOL_CYC(NOL_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .pwm_lvl_i  (pwm_lvl_i),
  .skip_lvl_i (skip_lvl_i),
  .hs_off_i   (hs_off_i),
  .ls_off_i   (ls_off_i),
  .gate_hs_o  (gate_hs_o),
  .gate_ls_o  (gate_ls_o)
);

// File: tb/test_tlpwm_gate_seq.sv
`timescale 1ns/1ps
module test_tlpwm_gate_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD_NS    = 20;
  localparam int BLANK_NS   = 250;
  localparam int DEB_NS     = 80;
  localparam int NOL  = (DEAD_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WAIT = (BLANK_NS + CLK_PERIOD - 1) / CLK_PERIOD
                      + (DEB_NS + CLK_PERIOD - 1) / CLK_PERIOD;

  localparam logic [1:0] L = 2'b00, M = 2'b01, H = 2'b10;

  typedef struct packed {
    logic        en;
    logic [1:0]  pwm;
    logic [1:0]  skip;
    logic        zcd;
    logic [15:0] cyc;
    logic        ehs;
    logic        els;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1, H, H, 1'b0, 16'(NOL),    1'b0, 1'b0, 8'd3},   // R3 dead time
    '{1'b1, H, H, 1'b0, 16'd1,       1'b1, 1'b0, 8'd3},   // R3 high side on
    '{1'b1, L, H, 1'b0, 16'(NOL),    1'b0, 1'b0, 8'd4},   // R4 high side off first
    '{1'b1, L, H, 1'b0, 16'd1,       1'b0, 1'b1, 8'd4},   // R4 low side on
    '{1'b1, M, H, 1'b0, 16'(WAIT),   1'b0, 1'b1, 8'd6},   // R6 held through window
    '{1'b1, M, H, 1'b0, 16'd1,       1'b0, 1'b1, 8'd7},   // R7 armed, still on
    '{1'b1, M, H, 1'b1, 16'd1,       1'b0, 1'b0, 8'd7},   // R7 released on zcd
    '{1'b1, M, H, 1'b0, 16'd3,       1'b0, 1'b0, 8'd7},   // R7 parked off
    '{1'b1, H, H, 1'b0, 16'(NOL+1),  1'b1, 1'b0, 8'd3},   // R3 from parked
    '{1'b1, M, M, 1'b1, 16'(NOL),    1'b0, 1'b0, 8'd9},   // R9 dead time to low side
    '{1'b1, M, M, 1'b1, 16'd1,       1'b0, 1'b1, 8'd9},   // R9 window started
    '{1'b1, M, M, 1'b1, 16'(WAIT-1), 1'b0, 1'b1, 8'd8},   // R8 early zcd ignored
    '{1'b1, M, M, 1'b1, 16'd1,       1'b0, 1'b0, 8'd8},   // R8 released at window end
    '{1'b1, L, H, 1'b0, 16'(NOL),    1'b0, 1'b0, 8'd4},   // R4
    '{1'b1, L, H, 1'b0, 16'd1,       1'b0, 1'b1, 8'd4},   // R4
    '{1'b1, M, L, 1'b0, 16'd1,       1'b0, 1'b0, 8'd10},  // R10 from low side
    '{1'b1, H, L, 1'b0, 16'(NOL+1),  1'b1, 1'b0, 8'd3},   // R3
    '{1'b1, M, L, 1'b0, 16'd1,       1'b0, 1'b0, 8'd10},  // R10 from high side
    '{1'b1, H, L, 1'b0, 16'(NOL+1),  1'b1, 1'b0, 8'd3},   // R3
    '{1'b0, H, L, 1'b0, 16'd1,       1'b0, 1'b0, 8'd2},   // R2 disable
    '{1'b0, L, H, 1'b0, 16'd3,       1'b0, 1'b0, 8'd2},   // R2 stays off
    '{1'b1, L, H, 1'b0, 16'(NOL),    1'b0, 1'b0, 8'd4},   // R4 from idle
    '{1'b1, L, H, 1'b0, 16'd1,       1'b0, 1'b1, 8'd4},   // R4
    '{1'b1, H, H, 1'b0, 16'd1,       1'b0, 1'b0, 8'd11},  // R11 dead time begun
    '{1'b1, L, H, 1'b0, 16'(NOL),    1'b0, 1'b0, 8'd11},  // R11 restarted
    '{1'b1, L, H, 1'b0, 16'd1,       1'b0, 1'b1, 8'd11},  // R11 low side back
    '{1'b1, M, H, 1'b0, 16'(WAIT+1), 1'b0, 1'b1, 8'd12},  // R12 continuous low side
    '{1'b1, M, H, 1'b0, 16'd20,      1'b0, 1'b1, 8'd7},   // R7 waits for zcd
    '{1'b1, L, H, 1'b0, 16'd1,       1'b0, 1'b1, 8'd12}   // R12 back to low, still on
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] pwm_lvl_i = L;
  logic [1:0] skip_lvl_i = H;
  logic       zcd_i = 1'b0;
  logic       hs_off_i, ls_off_i;
  logic       gate_hs_o, gate_ls_o;
  logic       fb_hs_q, fb_ls_q;
  logic       hold_ls = 1'b0;
  int         n_run = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Switch feedback model: reports "off" one cycle after the enable drops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_hs_q <= 1'b1;
      fb_ls_q <= 1'b1;
    end else begin
      fb_hs_q <= !gate_hs_o;
      fb_ls_q <= !gate_ls_o;
    end
  end
  assign hs_off_i = fb_hs_q;
  assign ls_off_i = fb_ls_q && !hold_ls;

  tlpwm_gate_seq #(
    .CLK_PERIOD_NS (CLK_PERIOD),
    .DEAD_NS       (DEAD_NS),
    .BLANK_NS      (BLANK_NS),
    .DEBOUNCE_NS   (DEB_NS)
  ) i_tlpwm_gate_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .pwm_lvl_i  (pwm_lvl_i),
    .skip_lvl_i (skip_lvl_i),
    .zcd_i      (zcd_i),
    .hs_off_i   (hs_off_i),
    .ls_off_i   (ls_off_i),
    .gate_hs_o  (gate_hs_o),
    .gate_ls_o  (gate_ls_o)
  );

  task automatic check(input int req, input logic ehs, input logic els);
    n_run++;
    if (gate_hs_o !== ehs || gate_ls_o !== els) begin
      n_fail++;
      $display("FAIL R%0d: hs=%0b ls=%0b expected hs=%0b ls=%0b at %0t",
               req, gate_hs_o, gate_ls_o, ehs, els, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: outputs low in reset and while disabled afterwards
    edges(2);
    check(1, 1'b0, 1'b0);
    rst_n = 1'b1;
    edges(3);
    check(1, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      en_i       = VECS[i].en;
      pwm_lvl_i  = VECS[i].pwm;
      skip_lvl_i = VECS[i].skip;
      zcd_i      = VECS[i].zcd;
      edges(int'(VECS[i].cyc));
      check(int'(VECS[i].req), VECS[i].ehs, VECS[i].els);
    end

    // R3: high side waits for low-side off feedback beyond the dead time
    hold_ls   = 1'b1;
    pwm_lvl_i = H;
    edges(NOL + 4);
    check(3, 1'b0, 1'b0);
    hold_ls = 1'b0;
    edges(1);
    check(3, 1'b1, 1'b0);

    // R8: a single early zcd pulse releases the low side exactly at window end
    pwm_lvl_i = L;
    edges(NOL + 1);
    check(4, 1'b0, 1'b1);
    pwm_lvl_i  = M;
    skip_lvl_i = H;
    edges(1);
    zcd_i = 1'b1;
    edges(1);
    zcd_i = 1'b0;
    edges(WAIT - 2);
    check(8, 1'b0, 1'b1);
    edges(1);
    check(8, 1'b0, 1'b0);

    // R2: enable drop in the middle of the wait window
    pwm_lvl_i = L;
    edges(NOL + 1);
    check(4, 1'b0, 1'b1);
    pwm_lvl_i = M;
    edges(5);
    check(6, 1'b0, 1'b1);
    en_i = 1'b0;
    edges(1);
    check(2, 1'b0, 1'b0);

    // R1: asynchronous reset while the high side is on
    en_i      = 1'b1;
    pwm_lvl_i = H;
    edges(NOL + 1);
    check(3, 1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    check(1, 1'b0, 1'b0);
    edges(2);
    check(1, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule